// File: doc/BRIEF.md
# 100 Mb/s Transmit Code-Group Framer

The framer sits between a MAC nibble interface and the line coder of a 100 Mb/s link. On every transmit clock it takes in one data nibble together with an enable and an error flag, and it puts out one 5-bit code-group. No clock passes without a code-group, so the line stream has no gaps.

Between frames the output is the Idle code-group. When the enable rises, the start-of-stream pair J, K is sent. This pair takes the place of the two nibbles of the first preamble octet, so the frame does not grow longer. The framer then 4B/5B-encodes every later nibble: the rest of the preamble, the start-of-frame delimiter, the data and the CRC. When the enable falls it appends the end-of-stream pair T, R and goes back to Idle. While a frame is being sent, the error flag turns a nibble into the H code-group. A frame whose enable drops during the first octet still gets a complete J, K before its T, R.

Inputs are registered once and the framing state machine registers the output, so results appear at a fixed latency.

Top module: `fx_tx_framer`

## Requirements
- R1: While rst_ni is low, and on the first clocks after it is released with the enable low, code_o is Idle (11111).
- R2: While no frame is in progress and tx_en_i is low, code_o carries Idle (11111) on every clock.
- R3: The first nibble slot with tx_en_i high after Idle gives J (11000), and the next slot gives K (10001).
- R4: In each later slot with tx_en_i high and tx_er_i low, the nibble is encoded. The table is 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R5: The first slot with tx_en_i low after encoded nibbles gives T (01101). The next slot gives R (00111), and the slot after that returns to Idle handling.
- R6: If tx_en_i is low in the slot after J, K is still sent, followed by T and then R.
- R7: tx_en_i and tx_er_i both high in an encoded-nibble slot gives H (00100). tx_er_i has no effect in the J and K slots and while tx_en_i is low.
- R8: The code-group for the inputs sampled at rising edge k appears on code_o just after rising edge k+1.
- R9: The value of txd_i in the two slots replaced by J and K has no effect on code_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit symbol clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Frame enable from the MAC |
| txd_i | input | 4 | Data nibble from the MAC |
| tx_er_i | input | 1 | Transmit error flag from the MAC |
| code_o | output | 5 | Code-group for the line, one per clock |

## Verification
Every code-group is due exactly two rising edges after its inputs are driven: one edge to sample the inputs and one edge to register the code. The bench drives inputs on falling edges and samples code_o on falling edges as well. It holds the expected values in a two-deep pipeline, so the value compared on each falling edge is the one predicted for the inputs driven two falling edges before. This applies to every slot alike, including the J/K substitution, the T/R tail and the H substitution, so no result needs its own timing.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CG_IDLE = 5'b11111;
  localparam code_t CG_J    = 5'b11000;
  localparam code_t CG_K    = 5'b10001;
  localparam code_t CG_T    = 5'b01101;
  localparam code_t CG_R    = 5'b00111;
  localparam code_t CG_H    = 5'b00100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K,
    ST_DATA,
    ST_T,
    ST_R
  } fr_state_e;
endpackage

// File: rtl/fx_in_stage.sv
module fx_in_stage
  import fx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  nib_t d_i,
  input  logic er_i,
  output logic en_o,
  output nib_t d_o,
  output logic er_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0;
      d_o  <= '0;
      er_o <= 1'b0;
    end else begin
      en_o <= en_i;
      d_o  <= d_i;
      er_o <= er_i;
    end
  end
endmodule

// File: rtl/fx_nibble_enc.sv
module fx_nibble_enc
  import fx_pkg::*;
(
  input  nib_t  nib_i,
  output code_t code_o
);
  always_comb begin
    unique case (nib_i)
      4'h0: code_o = 5'b11110;
      4'h1: code_o = 5'b01001;
      4'h2: code_o = 5'b10100;
      4'h3: code_o = 5'b10101;
      4'h4: code_o = 5'b01010;
      4'h5: code_o = 5'b01011;
      4'h6: code_o = 5'b01110;
      4'h7: code_o = 5'b01111;
      4'h8: code_o = 5'b10010;
      4'h9: code_o = 5'b10011;
      4'hA: code_o = 5'b10110;
      4'hB: code_o = 5'b10111;
      4'hC: code_o = 5'b11010;
      4'hD: code_o = 5'b11011;
      4'hE: code_o = 5'b11100;
      default: code_o = 5'b11101;
    endcase
  end
endmodule

// File: rtl/fx_frame_fsm.sv
module fx_frame_fsm
  import fx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  er_i,
  input  code_t enc_i,
  output code_t code_o
);
  fr_state_e st_q, st_d;
  code_t     code_d;

  always_comb begin
    st_d   = st_q;
    code_d = CG_IDLE;
    unique case (st_q)
      ST_IDLE: begin
        if (en_i) begin
          code_d = CG_J;
          st_d   = ST_K;
        end
      end
      ST_K: begin
        // K is always completed; an early drop still closes with T/R
        code_d = CG_K;
        st_d   = en_i ? ST_DATA : ST_T;
      end
      ST_DATA: begin
        if (en_i) begin
          code_d = er_i ? CG_H : enc_i;
        end else begin
          code_d = CG_T;
          st_d   = ST_R;
        end
      end
      ST_T: begin
        code_d = CG_T;
        st_d   = ST_R;
      end
      default: begin
        code_d = CG_R;
        st_d   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      code_o <= CG_IDLE;
    end else begin
      st_q   <= st_d;
      code_o <= code_d;
    end
  end

  p_idle_when_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !en_i) |=> (code_o == CG_IDLE));

  p_h_on_error_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && en_i && er_i) |=> (code_o == CG_H));

  p_k_closes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_K && !en_i) |=> ##1 (code_o == CG_T));
endmodule

// File: rtl/fx_tx_framer.sv
module fx_tx_framer
  import fx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_en_i,
  input  logic [3:0] txd_i,
  input  logic       tx_er_i,
  output logic [4:0] code_o
);
  logic  en_q, er_q;
  nib_t  d_q;
  code_t enc;

  fx_in_stage u_in (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tx_en_i),
    .d_i   (txd_i),
    .er_i  (tx_er_i),
    .en_o  (en_q),
    .d_o   (d_q),
    .er_o  (er_q)
  );

  fx_nibble_enc u_enc (
    .nib_i (d_q),
    .code_o(enc)
  );

  fx_frame_fsm u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_q),
    .er_i  (er_q),
    .enc_i (enc),
    .code_o(code_o)
  );

  p_j_then_k_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == CG_J) |=> (code_o == CG_K));

  p_t_then_r_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == CG_T) |=> (code_o == CG_R));

  p_r_then_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == CG_R) |=> (code_o == CG_IDLE || code_o == CG_J));

  p_quiet_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !en_q && code_o == CG_IDLE) |=> ##1 (code_o == CG_IDLE));
endmodule

// File: tb/fx_tx_framer_tb.sv
module fx_tx_framer_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       tx_er = 1'b0;
  logic [4:0] code;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  fx_tx_framer u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .tx_en_i(tx_en),
    .txd_i  (txd),
    .tx_er_i(tx_er),
    .code_o (code)
  );

  function automatic logic [4:0] enc4b5b(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  // reference model state: 0 idle, 1 K due, 2 data, 3 T due, 4 R due
  int m_st = 0;
  logic [4:0] e1 = 5'b11111, e2 = 5'b11111;
  string t1 = "R2", t2 = "R2";

  task automatic model(input bit en, input logic [3:0] d, input bit er,
                       output logic [4:0] c, output string tag);
    case (m_st)
      0: if (en) begin c = 5'b11000; tag = "R3/R9"; m_st = 1; end
         else begin c = 5'b11111; tag = "R2"; end
      1: begin c = 5'b10001; tag = en ? "R3/R9" : "R6"; m_st = en ? 2 : 3; end
      2: if (en) begin
           c = er ? 5'b00100 : enc4b5b(d); tag = er ? "R7" : "R4/R8";
         end else begin c = 5'b01101; tag = "R5"; m_st = 4; end
      3: begin c = 5'b01101; tag = "R6"; m_st = 4; end
      default: begin c = 5'b00111; tag = "R5"; m_st = 0; end
    endcase
  endtask

  task automatic check(input logic [4:0] got, input logic [4:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d got=%b exp=%b", tag, cyc, got, exp);
    end
  endtask

  task automatic slot(input bit en, input logic [3:0] d, input bit er);
    logic [4:0] c;
    string tg;
    @(negedge clk);
    cyc++;
    check(code, e2, t2);
    e2 = e1; t2 = t1;
    tx_en = en; txd = d; tx_er = er;
    model(en, d, er, c, tg);
    e1 = c; t1 = tg;
  endtask

  task automatic frame(input int ndata, input bit err_rand, input int gap);
    for (int i = 0; i < 15; i++) slot(1'b1, 4'h5, 1'b0);
    slot(1'b1, 4'hD, 1'b0);
    for (int i = 0; i < ndata; i++)
      slot(1'b1, 4'($urandom), err_rand && ($urandom % 16 == 0));
    for (int i = 0; i < gap; i++) slot(1'b0, 4'($urandom), 1'($urandom));
  endtask

  initial begin
    void'($urandom(32'd4217));
    // R1: reset state, inputs active during reset
    tx_en = 1'b1; tx_er = 1'b1; txd = 4'hA;
    repeat (3) @(negedge clk);
    check(code, 5'b11111, "R1");
    tx_en = 1'b0; tx_er = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(code, 5'b11111, "R1");
    for (int i = 0; i < 4; i++) slot(1'b0, 4'($urandom), 1'b1);
    // R4: every nibble value
    for (int i = 0; i < 2; i++) slot(1'b1, 4'h5, 1'b0);
    for (int n = 0; n < 16; n++) slot(1'b1, 4'(n), 1'b0);
    for (int i = 0; i < 6; i++) slot(1'b0, 4'h0, 1'b0);
    // R6: drop right after J, and a one-nibble frame
    slot(1'b1, 4'h5, 1'b1);
    slot(1'b0, 4'hF, 1'b1);
    for (int i = 0; i < 5; i++) slot(1'b0, 4'h0, 1'b0);
    // R9: J/K slots carry odd nibbles and errors
    slot(1'b1, 4'h0, 1'b1);
    slot(1'b1, 4'hF, 1'b1);
    slot(1'b1, 4'h3, 1'b1);  // R7: H
    slot(1'b1, 4'h3, 1'b0);
    for (int i = 0; i < 5; i++) slot(1'b0, 4'h0, 1'b0);
    // two-nibble frame: J K then T R
    slot(1'b1, 4'h5, 1'b0);
    slot(1'b1, 4'h5, 1'b0);
    for (int i = 0; i < 5; i++) slot(1'b0, 4'h0, 1'b0);
    // random frames
    for (int f = 0; f < 40; f++)
      frame(2 + int'($urandom % 30), 1'b1, 3 + int'($urandom % 12));
    for (int f = 0; f < 20; f++) begin
      int len = 1 + int'($urandom % 3);
      for (int i = 0; i < len; i++) slot(1'b1, 4'($urandom), 1'($urandom));
      for (int i = 0; i < 4 + int'($urandom % 4); i++) slot(1'b0, 4'($urandom), 1'($urandom));
    end
    slot(1'b0, 4'h0, 1'b0);
    slot(1'b0, 4'h0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule